// File: doc/BRIEF.md
# Dynamic Bus-Sizing Transfer Splitter

This block sits between a processor's transfer request and a 32-bit external data bus. A request carries a size (one byte, a 16-bit word, a 32-bit longword or a 16-byte line), a start address and, for writes, the data. The splitter turns the request into one or more bus beats. Each beat is as wide as the smaller of the transfer and the port width of the selected device. The port width comes from a 2-bit port-size code. Two enables, one for reads and one for writes, decide whether a transfer of several beats is run as a single burst or as a series of separate single cycles.

On writes, each beat's bytes are copied onto every byte lane of the bus. A narrow device then finds its data on the lanes it is wired to. On reads, each beat's bytes are taken from the lanes the device drives. The data is sampled only on the beat acknowledge. The bytes are packed in big-endian order into a right-aligned result. A one-cycle done pulse marks the end of the transfer. Chip-select decoding and wait-state counting happen elsewhere. The external acknowledge paces every beat.

Top module: `bus_sizer`

## Requirements
- R1: After reset, `bus_cyc`, `bus_start`, `bus_burst` and `done` are low and `rd_data` is zero.
- R2: Port-size code 00 is a 4-byte port, 01 is a 1-byte port, and 10 and 11 are both a 2-byte port. The beat width is the smaller of the transfer size and the port width. The beat count is the transfer size divided by the beat width. Size code 00 is a byte, 01 a word, 10 a longword and 11 a 16-byte line.
- R3: The first beat's `bus_addr` equals the request address. Each acknowledged beat that is not the last advances `bus_addr` by the beat width, so the bytes go in ascending address order.
- R4: During a write beat, `bus_dout` carries the beat's bytes repeated across all four lanes: a byte four times, a word twice, a longword once.
- R5: During a read beat, the beat's bytes are taken from `bus_din`. The lane index is `bus_addr` modulo the port width, with lane 0 being bits 31:24. A 1-byte port reads bits 31:24, and a 2-byte port reads bits 31:16 for a word or one of those two lanes for a byte.
- R6: When a read completes, `rd_data` holds the transfer's bytes right-aligned and zero-extended, with the lowest-addressed byte most significant.
- R7: For a read of more than one beat with `burst_rd_en` high, `bus_burst` is high on every beat and `bus_start` is high only on the first beat. With `burst_rd_en` low, `bus_burst` stays low and `bus_start` is high on every beat. `burst_wr_en` has no effect on reads.
- R8: Writes follow the same burst rule using `burst_wr_en`, and `burst_rd_en` has no effect on writes.
- R9: While `bus_ack` is low, the current beat holds: `bus_cyc`, `bus_addr` and `bus_dout` stay unchanged, and `bus_din` is not sampled.
- R10: `done` pulses high for one cycle, in the cycle after the final beat's acknowledge. A request presented while a transfer is in progress is ignored.
- R11: A transfer of one beat never asserts `bus_burst`, whatever the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_size | input | 2 | Transfer size code |
| req_addr | input | 32 | Start address, aligned to the size |
| req_wdata | input | 128 | Write data, right-aligned, big-endian |
| port_size | input | 2 | Port-size code of the selected device |
| burst_rd_en | input | 1 | Allow burst for multi-beat reads |
| burst_wr_en | input | 1 | Allow burst for multi-beat writes |
| bus_ack | input | 1 | Beat acknowledge |
| bus_din | input | 32 | Read data bus |
| bus_cyc | output | 1 | A beat is in progress |
| bus_addr | output | 32 | Address of the current beat |
| bus_we | output | 1 | Current beat is a write |
| bus_start | output | 1 | Current beat opens a new bus cycle |
| bus_burst | output | 1 | Current beat belongs to a burst |
| bus_dout | output | 32 | Write data with lanes replicated |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 128 | Assembled read data |

## Verification
The assertions assume that a request address is aligned to its transfer size. They also assume that `bus_ack` matters only while `bus_cyc` is high. The bench only issues aligned addresses and raises `bus_ack` only after it has seen `bus_cyc` at a falling edge. While a beat is stalled, the bench drives a garbage pattern on `bus_din` and on the unused lanes. Any sampling outside the acknowledged lanes therefore corrupts `rd_data`, which the bench checks against a byte-memory model.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_LINE = 2'b11
    } xfer_size_e;

    // log2 of the port width in bytes for a port-size code
    function automatic logic [1:0] port_lg(input logic [1:0] code);
        case (code)
            2'b00:   port_lg = 2'd2;
            2'b01:   port_lg = 2'd0;
            default: port_lg = 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/bsz_plan.sv
module bsz_plan import bsz_pkg::*; #(
    parameter int LINE_BYTES = 16,
    parameter int CNT_W      = $clog2(LINE_BYTES) + 1
) (
    input  xfer_size_e       size,
    input  logic [1:0]       port,
    input  logic             write,
    input  logic             brd_en,
    input  logic             bwr_en,
    output logic [1:0]       unit_lg,
    output logic [1:0]       port_mask,
    output logic [CNT_W-1:0] beats,
    output logic [CNT_W-1:0] nbytes,
    output logic             burst
);
    localparam int LINE_LG = $clog2(LINE_BYTES);

    logic [2:0] size_lg;
    logic [1:0] p_lg;

    always_comb begin
        case (size)
            SZ_BYTE: size_lg = 3'd0;
            SZ_WORD: size_lg = 3'd1;
            SZ_LONG: size_lg = 3'd2;
            default: size_lg = 3'(LINE_LG);
        endcase
        p_lg      = port_lg(port);
        unit_lg   = (size_lg < {1'b0, p_lg}) ? size_lg[1:0] : p_lg;
        port_mask = 2'((3'd1 << p_lg) - 3'd1);
        nbytes    = CNT_W'(1) << size_lg;
        beats     = CNT_W'(1) << (size_lg - {1'b0, unit_lg});
        burst     = (beats > CNT_W'(1)) && (write ? bwr_en : brd_en);
    end
endmodule

// File: rtl/bsz_lane.sv
module bsz_lane (
    input  logic [1:0]  unit_lg,
    input  logic [1:0]  lane_off,
    input  logic [31:0] wtop,
    input  logic [31:0] din,
    output logic [31:0] dout,
    output logic [31:0] rbeat
);
    logic [31:0] aligned;
    logic [5:0]  rshift;

    always_comb begin
        case (unit_lg)
            2'd0:    dout = {4{wtop[31:24]}};
            2'd1:    dout = {2{wtop[31:16]}};
            default: dout = wtop;
        endcase
        aligned = din << {lane_off, 3'b000};
        rshift  = 6'd32 - (6'd8 << unit_lg);
        rbeat   = aligned >> rshift;
    end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer import bsz_pkg::*; #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int DW         = 8 * LINE_BYTES,
    parameter int CNT_W      = $clog2(LINE_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [1:0]        port_size,
    input  logic              burst_rd_en,
    input  logic              burst_wr_en,
    input  logic              bus_ack,
    input  logic [31:0]       bus_din,
    output logic              bus_cyc,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic              bus_start,
    output logic              bus_burst,
    output logic [31:0]       bus_dout,
    output logic              done,
    output logic [DW-1:0]     rd_data
);
    typedef struct packed {
        logic              busy;
        logic              done;
        logic              write;
        logic              burst;
        logic              first;
        logic [1:0]        unit_lg;
        logic [1:0]        port_mask;
        logic [CNT_W-1:0]  left;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     wsh;
        logic [DW-1:0]     rsh;
    } state_t;

    state_t st_d, st_q;

    logic [1:0]       pl_unit_lg;
    logic [1:0]       pl_mask;
    logic [CNT_W-1:0] pl_beats;
    logic [CNT_W-1:0] pl_nbytes;
    logic             pl_burst;
    logic [31:0]      ln_rbeat;
    logic [31:0]      ln_dout;
    logic             beat_done;

    bsz_plan #(.LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)) u_plan (
        .size      (xfer_size_e'(req_size)),
        .port      (port_size),
        .write     (req_write),
        .brd_en    (burst_rd_en),
        .bwr_en    (burst_wr_en),
        .unit_lg   (pl_unit_lg),
        .port_mask (pl_mask),
        .beats     (pl_beats),
        .nbytes    (pl_nbytes),
        .burst     (pl_burst)
    );

    bsz_lane u_lane (
        .unit_lg  (st_q.unit_lg),
        .lane_off (st_q.addr[1:0] & st_q.port_mask),
        .wtop     (st_q.wsh[DW-1 -: 32]),
        .din      (bus_din),
        .dout     (ln_dout),
        .rbeat    (ln_rbeat)
    );

    assign beat_done = st_q.busy && bus_ack;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy      = 1'b1;
                st_d.write     = req_write;
                st_d.burst     = pl_burst;
                st_d.first     = 1'b1;
                st_d.unit_lg   = pl_unit_lg;
                st_d.port_mask = pl_mask;
                st_d.left      = pl_beats;
                st_d.addr      = req_addr;
                st_d.wsh       = req_wdata << (8 * (LINE_BYTES - int'(pl_nbytes)));
                st_d.rsh       = '0;
            end
        end else if (bus_ack) begin
            st_d.first = 1'b0;
            st_d.addr  = st_q.addr + (ADDR_W'(1) << st_q.unit_lg);
            st_d.wsh   = st_q.wsh << (6'd8 << st_q.unit_lg);
            if (!st_q.write)
                st_d.rsh = (st_q.rsh << (6'd8 << st_q.unit_lg)) | DW'(ln_rbeat);
            st_d.left = st_q.left - CNT_W'(1);
            if (st_q.left == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_cyc   = st_q.busy;
    assign bus_addr  = st_q.addr;
    assign bus_we    = st_q.busy && st_q.write;
    assign bus_start = st_q.busy && (st_q.first || !st_q.burst);
    assign bus_burst = st_q.busy && st_q.burst;
    assign bus_dout  = ln_dout;
    assign done      = st_q.done;
    assign rd_data   = st_q.rsh;

    // Input assumption: request addresses are aligned to the transfer size
    assert_req_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && req_valid) |-> ((req_addr[CNT_W-1:0] & (pl_nbytes - CNT_W'(1))) == '0));

    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && st_q.left > CNT_W'(1)) |=>
            (bus_cyc && bus_addr == $past(bus_addr) + (ADDR_W'(1) << $past(st_q.unit_lg))));

    assert_byte_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && st_q.unit_lg == 2'd0) |->
            (bus_dout[31:24] == bus_dout[7:0] && bus_dout[23:16] == bus_dout[15:8]
             && bus_dout[31:24] == bus_dout[15:8]));

    assert_burst_one_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && bus_burst) |=> !bus_start);

    assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ack) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_dout)));

    assert_done_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(beat_done));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_single_no_burst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && st_q.first && st_q.left == CNT_W'(1)) |-> !bus_burst);
endmodule

// File: tb/sim_bus_sizer.sv
module sim_bus_sizer;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_write;
    logic [1:0]   req_size, port_size;
    logic [31:0]  req_addr;
    logic [127:0] req_wdata;
    logic         burst_rd_en, burst_wr_en, bus_ack;
    logic [31:0]  bus_din;
    logic         bus_cyc, bus_we, bus_start, bus_burst, done;
    logic [31:0]  bus_addr, bus_dout;
    logic [127:0] rd_data;

    int errors = 0;
    int checks = 0;
    logic [7:0] mem [64];

    always #5 clk = ~clk;

    bus_sizer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .port_size(port_size), .burst_rd_en(burst_rd_en), .burst_wr_en(burst_wr_en),
        .bus_ack(bus_ack), .bus_din(bus_din), .bus_cyc(bus_cyc), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_start(bus_start), .bus_burst(bus_burst),
        .bus_dout(bus_dout), .done(done), .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One transfer; wr selects the burst enable under test, the other is set opposite
    task automatic xfer(input logic wr, input int sz, input logic [31:0] a,
                        input logic [1:0] ps, input logic be, input logic [127:0] wd,
                        input logic stall, input logic poke);
        int n, w, unit, beats, k;
        logic burst;
        logic [127:0] exp;
        logic [31:0] ed, din;
        logic [31:0] held;
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 16;
        w = (ps == 2'b00) ? 4 : (ps == 2'b01) ? 1 : 2;
        unit  = (n < w) ? n : w;
        beats = n / unit;
        burst = (beats > 1) && be;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = 2'(sz); req_addr = a;
        req_wdata = wd; port_size = ps;
        burst_rd_en = wr ? !be : be;
        burst_wr_en = wr ? be : !be;
        @(negedge clk);
        req_valid = 1'b0;
        for (k = 0; k < beats; k++) begin
            if (!bus_cyc) begin
                chk("R2", "beat present", 0, 1);
                break;
            end
            if (stall) begin
                held = bus_addr;
                bus_ack = 1'b0; bus_din = 32'hDEADBEEF;
                @(negedge clk);
                chk("R9", "stall holds cycle", bus_cyc, 1);
                chk("R9", "stall holds addr", bus_addr, held);
            end
            chk("R3", "beat addr", bus_addr, a + k * unit);
            chk(wr ? "R8" : "R7", "burst flag", bus_burst, burst);
            chk(wr ? "R8" : "R7", "start flag", bus_start, (k == 0) || !burst);
            chk("R4", "write flag", bus_we, wr);
            if (wr) begin
                for (int b = 0; b < 4; b++) begin
                    int j;
                    j = k * unit + (b % unit);
                    ed[31 - 8 * b -: 8] = wd[8 * (n - 1 - j) +: 8];
                end
                chk("R4", "write lanes", bus_dout, ed);
            end
            for (int b = 0; b < 4; b++)
                din[31 - 8 * b -: 8] = (b < w)
                    ? mem[6'(((a + k * unit) & ~(w - 1)) + b)] : 8'hEE;
            bus_din = din; bus_ack = 1'b1;
            if (poke && k == 1) begin
                req_valid = 1'b1; req_size = 2'd0; req_addr = 32'h1000_0030; req_write = !wr;
            end
            @(negedge clk);
            bus_ack = 1'b0; req_valid = 1'b0; bus_din = 32'hDEADBEEF;
        end
        chk("R10", "done after last ack", done, 1);
        chk("R10", "idle after last ack", bus_cyc, 0);
        if (!wr) begin
            exp = '0;
            for (int j = 0; j < n; j++) exp = (exp << 8) | 128'(mem[6'(a + j)]);
            chk("R6", "read data", rd_data, exp);
        end
        @(negedge clk);
        chk("R10", "done one cycle", done, 0);
        chk("R10", "no stray request taken", bus_cyc, 0);
    endtask

    task automatic t_reset();
        chk("R1", "cyc", bus_cyc, 0);
        chk("R1", "start", bus_start, 0);
        chk("R1", "burst", bus_burst, 0);
        chk("R1", "done", done, 0);
        chk("R1", "rd_data", rd_data, 0);
    endtask

    task automatic t_reads();
        xfer(0, 2, 32'h1000_0004, 2'b01, 0, '0, 0, 0); // R7 split long on byte port
        xfer(0, 2, 32'h1000_0008, 2'b01, 1, '0, 0, 0); // R7 burst
        xfer(0, 3, 32'h1000_0010, 2'b00, 1, '0, 1, 0); // R9 line with stalls
        xfer(0, 1, 32'h1000_0022, 2'b11, 1, '0, 0, 0); // R2 code 11 is 16-bit
        xfer(0, 2, 32'h1000_0024, 2'b10, 1, '0, 0, 0); // R2 code 10 long burst
        xfer(0, 0, 32'h1000_0003, 2'b00, 1, '0, 0, 0); // R5 lane 3 on 32-bit
        xfer(0, 0, 32'h1000_0001, 2'b00, 0, '0, 0, 0); // R5 lane 1
        xfer(0, 0, 32'h1000_0005, 2'b10, 0, '0, 0, 0); // R5 byte lane 1 of 16-bit
        xfer(0, 3, 32'h1000_0020, 2'b01, 0, '0, 0, 1); // R10 poke, 16 split beats
    endtask

    task automatic t_writes();
        xfer(1, 1, 32'h1000_0002, 2'b01, 1, 128'h0A1B, 0, 0);        // R8 burst
        xfer(1, 2, 32'h1000_0004, 2'b10, 0, 128'hC0FFEE11, 1, 0);    // R8 split
        xfer(1, 3, 32'h1000_0030, 2'b11, 1,
             128'h00112233_44556677_8899AABB_CCDDEEFF, 0, 1);        // R4 line
        xfer(1, 0, 32'h1000_0007, 2'b00, 1, 128'h5A, 0, 0);          // R11 single
        xfer(1, 1, 32'h1000_0006, 2'b00, 1, 128'h9876, 0, 0);        // R11 word twice
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'(i * 29 + 53);
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
        req_addr = '0; req_wdata = '0; port_size = 2'd0;
        burst_rd_en = 1'b0; burst_wr_en = 1'b0; bus_ack = 1'b0; bus_din = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reads();
        t_writes();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule